// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small stored-program processor that keeps code and data in one memory and reaches it through a single synchronous port. Each instruction passes through a fetch, a decode and an execute phase. Every phase is split into clock states, and each state performs at most one register transfer among the program counter, the memory address register, the memory data register, the instruction register and the accumulator.

The memory address output always comes from the address register, and the write-data output always comes from the data register. A store therefore first stages its value in the data register and then writes it in a separate state. The program counter advances during fetch. A jump simply replaces that advanced value. Debug outputs show every register and the controller state, so a surrounding test environment can follow the machine cycle by cycle.

Top module: `acc_cpu_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, address register, data register, instruction register and accumulator to zero and puts the controller in the fetch-address state (code 0).
- R2: An instruction word carries its opcode in bits 15:12 and a 12-bit memory address in bits 11:0. Opcode 0 loads, 1 adds, 2 stores and 3 jumps.
- R3: Fetch performs, in separate states and in this order: PC to MAR, memory at MAR to MDR, MDR to IR, then PC plus one. Decode follows, so decode is the sixth state after the start of a fetch.
- R4: The PC is incremented during fetch, before execute, and it wraps from 4095 to 0.
- R5: Decode makes no memory access and changes neither MAR, MDR nor ACC.
- R6: A load puts its address field in MAR, reads that word into MDR, then copies MDR into ACC. It takes 10 cycles in total.
- R7: An add reads its operand the same way, then writes ACC plus MDR into ACC modulo 2^16. It takes 10 cycles in total.
- R8: A store puts its address field in MAR, copies ACC into MDR, then asserts the write enable for exactly one cycle with address = MAR and write data = MDR. It takes 9 cycles in total.
- R9: A jump loads its address field into the PC and discards the incremented value. It takes 7 cycles, and the next fetch starts at the target.
- R10: Opcodes 4 to 15 change no register after fetch. The next fetch starts right after decode.
- R11: Memory reads have one cycle of latency. The address output always equals MAR, and MDR captures the read data two states after MAR is loaded (one wait state in between).
- R12: The state output uses these codes: 0 fetch-address, 1 fetch-wait, 2 fetch-data, 3 fetch-IR, 4 fetch-increment, 5 decode, 6 operand-address, 7 operand-wait, 8 operand-data, 9 load-ACC, 10 add-ACC, 11 store-stage, 12 store-write, 13 jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory address, taken from MAR |
| mem_wdata | output | 16 | Memory write data, taken from MDR |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Registered memory read data |
| dbg_pc | output | 12 | Program counter |
| dbg_mar | output | 12 | Memory address register |
| dbg_mdr | output | 16 | Memory data register |
| dbg_ir | output | 16 | Instruction register |
| dbg_acc | output | 16 | Accumulator |
| dbg_state | output | 4 | Controller state code |

## Verification
Each transfer appears on the debug outputs one clock after its state. A memory word shows up in MDR two clocks after MAR takes the address, and a new ACC or PC value is visible one clock after the load-ACC, add-ACC or jump state. The bench runs its own cycle-level model, which advances on the same rising edge as the design. It compares every register, the state code and the memory pins at the following falling edge, so every result is checked in exactly the cycle it is due. Instruction lengths of 6, 7, 9 and 10 cycles follow from the state codes matching on every cycle.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [3:0] {
    ST_F_ADDR   = 4'd0,
    ST_F_WAIT   = 4'd1,
    ST_F_DATA   = 4'd2,
    ST_F_IR     = 4'd3,
    ST_F_INC    = 4'd4,
    ST_DECODE   = 4'd5,
    ST_X_ADDR   = 4'd6,
    ST_X_WAIT   = 4'd7,
    ST_X_DATA   = 4'd8,
    ST_X_LOAD   = 4'd9,
    ST_X_ADD    = 4'd10,
    ST_X_STDATA = 4'd11,
    ST_X_WRITE  = 4'd12,
    ST_X_JUMP   = 4'd13
  } cpu_state_e;

  localparam int OPC_LOAD  = 0;
  localparam int OPC_ADD   = 1;
  localparam int OPC_STORE = 2;
  localparam int OPC_JUMP  = 3;

  // one-hot set of register transfers requested by the controller
  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic mdr_mem;
    logic mdr_acc;
    logic ir_mdr;
    logic pc_inc;
    logic pc_jump;
    logic acc_load;
    logic acc_add;
    logic mem_write;
  } xfer_t;

endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int OPC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output cpu_state_e       state,
  output xfer_t            xfer
);

  cpu_state_e state_nx;

  logic is_load, is_add, is_store, is_jump, is_mem_op;
  assign is_load   = (opcode == OPC_W'(OPC_LOAD));
  assign is_add    = (opcode == OPC_W'(OPC_ADD));
  assign is_store  = (opcode == OPC_W'(OPC_STORE));
  assign is_jump   = (opcode == OPC_W'(OPC_JUMP));
  assign is_mem_op = is_load | is_add | is_store;

  always_comb begin
    state_nx = ST_F_ADDR;
    unique case (state)
      ST_F_ADDR:   state_nx = ST_F_WAIT;
      ST_F_WAIT:   state_nx = ST_F_DATA;
      ST_F_DATA:   state_nx = ST_F_IR;
      ST_F_IR:     state_nx = ST_F_INC;
      ST_F_INC:    state_nx = ST_DECODE;
      ST_DECODE: begin
        if (is_mem_op)    state_nx = ST_X_ADDR;
        else if (is_jump) state_nx = ST_X_JUMP;
        else              state_nx = ST_F_ADDR;
      end
      ST_X_ADDR:   state_nx = is_store ? ST_X_STDATA : ST_X_WAIT;
      ST_X_WAIT:   state_nx = ST_X_DATA;
      ST_X_DATA:   state_nx = is_add ? ST_X_ADD : ST_X_LOAD;
      ST_X_LOAD:   state_nx = ST_F_ADDR;
      ST_X_ADD:    state_nx = ST_F_ADDR;
      ST_X_STDATA: state_nx = ST_X_WRITE;
      ST_X_WRITE:  state_nx = ST_F_ADDR;
      ST_X_JUMP:   state_nx = ST_F_ADDR;
      default:     state_nx = ST_F_ADDR;
    endcase
  end

  always_comb begin
    xfer = '0;
    case (state)
      ST_F_ADDR:   xfer.mar_pc    = 1'b1;
      ST_F_DATA:   xfer.mdr_mem   = 1'b1;
      ST_F_IR:     xfer.ir_mdr    = 1'b1;
      ST_F_INC:    xfer.pc_inc    = 1'b1;
      ST_X_ADDR:   xfer.mar_ir    = 1'b1;
      ST_X_DATA:   xfer.mdr_mem   = 1'b1;
      ST_X_LOAD:   xfer.acc_load  = 1'b1;
      ST_X_ADD:    xfer.acc_add   = 1'b1;
      ST_X_STDATA: xfer.mdr_acc   = 1'b1;
      ST_X_WRITE:  xfer.mem_write = 1'b1;
      ST_X_JUMP:   xfer.pc_jump   = 1'b1;
      default:     xfer = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_F_ADDR;
    else     state <= state_nx;
  end

  // at most one register transfer per state (R3)
  assert_one_xfer_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(xfer));

  // an opcode without a defined meaning returns straight to fetch (R10)
  assert_nop_refetch_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && !is_mem_op && !is_jump) |=> (state == ST_F_ADDR));

  // the store path never enters the read wait state (R8)
  assert_store_path_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_X_ADDR && is_store) |=> (state == ST_X_STDATA));

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  xfer_t             xfer,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] acc
);

  function automatic logic [DATA_W-1:0] acc_sum(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [ADDR_W-1:0] pc_next_seq(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(1);
  endfunction

  logic [ADDR_W-1:0] ir_addr;
  assign ir_addr = ir[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
      acc <= '0;
    end else begin
      if (xfer.mar_pc)        mar <= pc;
      else if (xfer.mar_ir)   mar <= ir_addr;
      if (xfer.mdr_mem)       mdr <= mem_rdata;
      else if (xfer.mdr_acc)  mdr <= acc;
      if (xfer.ir_mdr)        ir  <= mdr;
      if (xfer.pc_inc)        pc  <= pc_next_seq(pc);
      else if (xfer.pc_jump)  pc  <= ir_addr;
      if (xfer.acc_load)      acc <= mdr;
      else if (xfer.acc_add)  acc <= acc_sum(acc, mdr);
    end
  end

  // MDR takes the read word (R11)
  assert_mdr_capture_R11: assert property (@(posedge clk) disable iff (rst)
    xfer.mdr_mem |=> (mdr == $past(mem_rdata)));

  // MDR copied to IR (R3)
  assert_ir_copy_R3: assert property (@(posedge clk) disable iff (rst)
    xfer.ir_mdr |=> (ir == $past(mdr)));

  // add wraps modulo 2^DATA_W (R7)
  assert_add_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    xfer.acc_add |=> (acc == DATA_W'($past(acc) + $past(mdr))));

  // load copies MDR (R6)
  assert_load_acc_R6: assert property (@(posedge clk) disable iff (rst)
    xfer.acc_load |=> (acc == $past(mdr)));

  // nothing moves while memory is written (R8)
  assert_write_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    xfer.mem_write |=> ($stable(mar) && $stable(mdr) && $stable(acc)));

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [ADDR_W-1:0] dbg_mar,
  output logic [DATA_W-1:0] dbg_mdr,
  output logic [DATA_W-1:0] dbg_ir,
  output logic [DATA_W-1:0] dbg_acc,
  output logic [3:0]        dbg_state
);

  localparam int OPC_W = DATA_W - ADDR_W;

  cpu_state_e        state;
  xfer_t             xfer;
  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mdr, ir, acc;
  logic [OPC_W-1:0]  opcode;

  // named internal events for the checks below
  logic ev_fetch_inc, ev_jump, ev_decode, ev_write;

  assign opcode = ir[DATA_W-1:ADDR_W];

  acc_cpu_ctrl #(.OPC_W(OPC_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .state  (state),
    .xfer   (xfer)
  );

  acc_cpu_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .xfer      (xfer),
    .mem_rdata (mem_rdata),
    .pc        (pc),
    .mar       (mar),
    .mdr       (mdr),
    .ir        (ir),
    .acc       (acc)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_we    = xfer.mem_write;

  assign dbg_pc    = pc;
  assign dbg_mar   = mar;
  assign dbg_mdr   = mdr;
  assign dbg_ir    = ir;
  assign dbg_acc   = acc;
  assign dbg_state = state;

  assign ev_fetch_inc = (state == ST_F_INC);
  assign ev_jump      = (state == ST_X_JUMP);
  assign ev_decode    = (state == ST_DECODE);
  assign ev_write     = (state == ST_X_WRITE);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (state == ST_F_ADDR && pc == '0 && mar == '0 && mdr == '0 &&
             ir == '0 && acc == '0));

  assert_fetch_mar_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_F_ADDR) |=> (mar == $past(pc) && state == ST_F_WAIT));

  assert_pc_inc_R4: assert property (@(posedge clk) disable iff (rst)
    ev_fetch_inc |=> (pc == ADDR_W'($past(pc) + 1) && state == ST_DECODE));

  assert_decode_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    ev_decode |-> (!mem_we ##1 ($stable(mar) && $stable(mdr) && $stable(acc))));

  assert_jump_target_R9: assert property (@(posedge clk) disable iff (rst)
    ev_jump |=> (pc == $past(ir[ADDR_W-1:0]) && state == ST_F_ADDR));

  assert_we_single_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_we_in_write_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (ev_write && mem_wdata == $past(acc)));

  assert_operand_addr_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_X_ADDR) |=> (mem_addr == $past(ir[ADDR_W-1:0])));

endmodule

// File: tb/acc_cpu_core_test.sv
module acc_cpu_core_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata = 16'h0;
  logic [11:0] dbg_pc, dbg_mar;
  logic [15:0] dbg_mdr, dbg_ir, dbg_acc;
  logic [3:0]  dbg_state;

  logic [15:0] mem [0:4095];

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state
  int m_pc, m_mar, m_mdr, m_ir, m_acc, m_st, m_op;

  acc_cpu_core uut (
    .clk(clk), .rst(rst),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata),
    .dbg_pc(dbg_pc), .dbg_mar(dbg_mar), .dbg_mdr(dbg_mdr),
    .dbg_ir(dbg_ir), .dbg_acc(dbg_acc), .dbg_state(dbg_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // synchronous memory, one cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  // behavioural reference: one step of the instruction walk per clock
  always @(posedge clk) begin
    if (rst) begin
      m_pc = 0; m_mar = 0; m_mdr = 0; m_ir = 0; m_acc = 0; m_st = 0;
    end else begin
      m_op = m_ir / 4096;
      case (m_st)
        0:  begin m_mar = m_pc; m_st = 1; end
        1:  m_st = 2;
        2:  begin m_mdr = int'(mem[m_mar]); m_st = 3; end
        3:  begin m_ir = m_mdr; m_st = 4; end
        4:  begin m_pc = (m_pc + 1) % 4096; m_st = 5; end
        5:  begin
              if (m_op <= 2)      m_st = 6;
              else if (m_op == 3) m_st = 13;
              else                m_st = 0;
            end
        6:  begin m_mar = m_ir % 4096; m_st = (m_op == 2) ? 11 : 7; end
        7:  m_st = 8;
        8:  begin m_mdr = int'(mem[m_mar]); m_st = (m_op == 1) ? 10 : 9; end
        9:  begin m_acc = m_mdr; m_st = 0; end
        10: begin m_acc = (m_acc + m_mdr) % 65536; m_st = 0; end
        11: begin m_mdr = m_acc; m_st = 12; end
        12: m_st = 0;
        13: begin m_pc = m_ir % 4096; m_st = 0; end
        default: m_st = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R12 state", int'(dbg_state), m_st);
    chk("R4 pc", int'(dbg_pc), m_pc);
    chk("R11 mar", int'(dbg_mar), m_mar);
    chk("R11 mem_addr", int'(mem_addr), m_mar);
    chk("R3 mdr", int'(dbg_mdr), m_mdr);
    chk("R3 ir", int'(dbg_ir), m_ir);
    chk("R7 acc", int'(dbg_acc), m_acc);
    chk("R8 we", int'(mem_we), (m_st == 12) ? 1 : 0);
    if (m_st == 12) chk("R8 wdata", int'(mem_wdata), m_mdr);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
    mem[12'h000] = 16'h0100;  // R2 load 0x100
    mem[12'h001] = 16'h1101;  // add 0x101
    mem[12'h002] = 16'h2102;  // store 0x102
    mem[12'h003] = 16'h0102;  // load 0x102
    mem[12'h004] = 16'h7ABC;  // R10 undefined opcode
    mem[12'h005] = 16'h1103;  // add 0xFFFF, wraps
    mem[12'h006] = 16'h2104;  // store 0x104
    mem[12'h007] = 16'h3020;  // R9 jump 0x020
    mem[12'h020] = 16'h0104;
    mem[12'h021] = 16'h3FFF;  // jump to last word
    mem[12'hFFF] = 16'h1101;  // R4 pc wraps to 0 after this fetch
    mem[12'h100] = 16'h1234;
    mem[12'h101] = 16'h8001;
    mem[12'h103] = 16'hFFFF;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 pc", int'(dbg_pc), 0);
    chk("R1 acc", int'(dbg_acc), 0);
    chk("R1 ir", int'(dbg_ir), 0);
    chk("R1 state", int'(dbg_state), 0);
    rst = 1'b0;

    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      compare_all();
    end

    // R8 R7 R6 stored results in memory
    chk("R8 mem102", int'(mem[12'h102]), 16'h9235);
    chk("R7 mem104", int'(mem[12'h104]), 16'h9234);

    // R1 reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    compare_all();
    chk("R1 midrun pc", int'(dbg_pc), 0);
    chk("R1 midrun mdr", int'(dbg_mdr), 0);
    rst = 1'b0;
    for (int c = 0; c < 150; c++) begin
      @(negedge clk);
      compare_all();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule